// File: doc/BRIEF.md
# Cache Maintenance Operation Engine

This block is the control side of an outer cache. Software programs it through a small 32-bit register window. It can enable the cache, set two auxiliary enables (event reporting and error correction), and request maintenance on the cache contents. The scope of a maintenance request is either the whole cache or a span of cache-line indices. A request is a clean, an invalidate, or a clean-plus-invalidate.

Once launched, the engine walks the selected lines one at a time. For each line it issues a command on a valid/acknowledge port that faces the cache arrays. It waits for the acknowledge before moving to the next line. A single start/status bit in the maintenance control word launches the request. The same bit reads 1 while the walk runs and drops to 0 when the walk is finished, so software only has to poll that bit.

Range bounds are line indices, which are physical addresses with the 6 line-offset bits removed. The end bound is exclusive. Whole-cache walks cover every set/way slot of a parameterised geometry.

Top module: `cache_maint_engine`

## Requirements
- R1: After reset every register reads 0, all enable outputs are 0, and no command is presented.
- R2: Offset 0x00 bit 0 is the cache enable. It is read/write and drives `cache_en`.
- R3: Offset 0x04 holds two read/write enables: bit 23 (event reporting, drives `event_en`) and bit 8 (error correction, drives `ecc_en`). All other bits of this register read 0.
- R4: Offsets 0x24 (first line) and 0x28 (exclusive end line) each hold a 30-bit line index in bits 29:0. Bits 31:30 read 0.
- R5: Offset 0x20 is the maintenance word, with these fields:
  - bit 3 selects the scope: 1 is the line range, 0 is the whole cache;
  - bits 2:1 are the operation: 1 is clean, 2 is invalidate, 3 is both;
  - bit 0 is start/status.

  Writing bit 0 = 1 with a non-zero operation launches a walk. Bit 0 then reads 1 until the walk completes and 0 afterwards.
- R6: In range scope exactly one command is issued per index from first to end−1, in increasing order. Each command carries the requested operation on `cmd_op`.
- R7: A command holds `cmd_valid`, `cmd_index` and `cmd_op` steady until `cmd_ack`. Only one command is outstanding at a time.
- R8: In whole-cache scope the commands cover indices 0 to 2^(SETS_LOG2+WAYS_LOG2)−1 in increasing order. The range registers are not used.
- R9: A range launch with first ≥ end completes without issuing any command.
- R10: While bit 0 of offset 0x20 reads 1, writes to offsets 0x20, 0x24 and 0x28 have no effect.
- R11: A launch write with operation 0 starts nothing. Bit 0 stays 0 and no command is issued.
- R12: `rd_data` presents the register selected by `rd_addr` one clock later. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write byte offset |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | ADDR_W | Register read byte offset |
| rd_data | output | DATA_W | Registered read data |
| cache_en | output | 1 | Cache enable |
| event_en | output | 1 | Event reporting enable |
| ecc_en | output | 1 | Error-correction enable |
| cmd_valid | output | 1 | Per-line command valid |
| cmd_op | output | 2 | Command operation: 1 clean, 2 invalidate, 3 both |
| cmd_index | output | IDX_W | Line index (range) or flat set/way slot (whole) |
| cmd_ack | input | 1 | Cache side accepts the current command |

## Verification
The assertions assume that `cmd_ack` is raised only while `cmd_valid` is high. They also assume that the cache side lowers `cmd_ack` in the cycle after a handshake, so that every acknowledge consumes exactly one command. The bench's responder keeps to this. It raises acknowledge only on a valid command, after a rotating delay of 0 to 2 cycles, and clears it one cycle later.

The ordering and bound checks rely on the range registers staying frozen during a walk. The stimulus deliberately writes those registers while a walk is running, and the assertions confirm that the freeze holds.

// File: rtl/cme_pkg.sv
package cme_pkg;
  localparam logic [7:0] OFF_GCTRL = 8'h00;
  localparam logic [7:0] OFF_AUX   = 8'h04;
  localparam logic [7:0] OFF_MCTRL = 8'h20;
  localparam logic [7:0] OFF_LO    = 8'h24;
  localparam logic [7:0] OFF_HI    = 8'h28;

  localparam int AUX_EVT_BIT = 23;
  localparam int AUX_ECC_BIT = 8;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_CLEAN = 2'd1,
    OP_INV   = 2'd2,
    OP_FLUSH = 2'd3
  } maint_op_e;

  typedef enum logic {
    W_IDLE = 1'b0,
    W_RUN  = 1'b1
  } walk_state_e;
endpackage

// File: rtl/cme_regs.sv
module cme_regs
  import cme_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              eng_busy,
  output logic              cache_en,
  output logic              event_en,
  output logic              ecc_en,
  output logic [IDX_W-1:0]  lo_idx,
  output logic [IDX_W-1:0]  hi_idx,
  output logic              scope_q,
  output maint_op_e         op_q,
  output logic              launch,
  output logic              launch_scope,
  output maint_op_e         launch_op
);
  localparam logic [ADDR_W-1:0] A_GCTRL = ADDR_W'(OFF_GCTRL);
  localparam logic [ADDR_W-1:0] A_AUX   = ADDR_W'(OFF_AUX);
  localparam logic [ADDR_W-1:0] A_MCTRL = ADDR_W'(OFF_MCTRL);
  localparam logic [ADDR_W-1:0] A_LO    = ADDR_W'(OFF_LO);
  localparam logic [ADDR_W-1:0] A_HI    = ADDR_W'(OFF_HI);

  logic maint_wr, lo_wr, hi_wr;
  logic [DATA_W-1:0] rd_next;

  // Writes that can disturb a walk are blocked while it runs.
  assign maint_wr     = wr_en && (wr_addr == A_MCTRL) && !eng_busy;
  assign lo_wr        = wr_en && (wr_addr == A_LO) && !eng_busy;
  assign hi_wr        = wr_en && (wr_addr == A_HI) && !eng_busy;
  assign launch_scope = wr_data[3];
  assign launch_op    = maint_op_e'(wr_data[2:1]);
  assign launch       = maint_wr && wr_data[0] && (launch_op != OP_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cache_en <= 1'b0;
      event_en <= 1'b0;
      ecc_en   <= 1'b0;
      lo_idx   <= '0;
      hi_idx   <= '0;
      scope_q  <= 1'b0;
      op_q     <= OP_NONE;
    end else begin
      if (wr_en && (wr_addr == A_GCTRL)) cache_en <= wr_data[0];
      if (wr_en && (wr_addr == A_AUX)) begin
        event_en <= wr_data[AUX_EVT_BIT];
        ecc_en   <= wr_data[AUX_ECC_BIT];
      end
      if (lo_wr) lo_idx <= wr_data[IDX_W-1:0];
      if (hi_wr) hi_idx <= wr_data[IDX_W-1:0];
      if (maint_wr) begin
        scope_q <= launch_scope;
        op_q    <= launch_op;
      end
    end
  end

  always_comb begin
    rd_next = '0;
    if (rd_addr == A_GCTRL) begin
      rd_next[0] = cache_en;
    end else if (rd_addr == A_AUX) begin
      rd_next[AUX_EVT_BIT] = event_en;
      rd_next[AUX_ECC_BIT] = ecc_en;
    end else if (rd_addr == A_MCTRL) begin
      rd_next[3]   = scope_q;
      rd_next[2:1] = op_q;
      rd_next[0]   = eng_busy;
    end else if (rd_addr == A_LO) begin
      rd_next[IDX_W-1:0] = lo_idx;
    end else if (rd_addr == A_HI) begin
      rd_next[IDX_W-1:0] = hi_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end
endmodule

// File: rtl/cme_walker.sv
module cme_walker
  import cme_pkg::*;
#(
  parameter int IDX_W     = 30,
  parameter int SETS_LOG2 = 4,
  parameter int WAYS_LOG2 = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             launch,
  input  logic             launch_scope,
  input  maint_op_e        launch_op,
  input  logic [IDX_W-1:0] lo_idx,
  input  logic [IDX_W-1:0] hi_idx,
  input  logic             cmd_ack,
  output logic             busy,
  output logic             cmd_valid,
  output logic [IDX_W-1:0] cmd_index,
  output maint_op_e        cmd_op
);
  localparam int CUR_W    = IDX_W + 1;
  localparam int GEO_LOG2 = SETS_LOG2 + WAYS_LOG2;
  localparam logic [CUR_W-1:0] WHOLE_LINES = CUR_W'(1) << GEO_LOG2;

  walk_state_e state;
  logic [CUR_W-1:0] cur, lim;

  assign busy = (state == W_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= W_IDLE;
      cur       <= '0;
      lim       <= '0;
      cmd_valid <= 1'b0;
      cmd_index <= '0;
      cmd_op    <= OP_NONE;
    end else begin
      case (state)
        W_IDLE: begin
          if (launch) begin
            state  <= W_RUN;
            cmd_op <= launch_op;
            if (launch_scope) begin
              cur <= {1'b0, lo_idx};
              lim <= {1'b0, hi_idx};
            end else begin
              cur <= '0;
              lim <= WHOLE_LINES;
            end
          end
        end
        W_RUN: begin
          if (cmd_valid) begin
            if (cmd_ack) begin
              cmd_valid <= 1'b0;
              cur       <= cur + 1'b1;
            end
          end else if (cur >= lim) begin
            state <= W_IDLE;
          end else begin
            cmd_valid <= 1'b1;
            cmd_index <= cur[IDX_W-1:0];
          end
        end
        default: state <= W_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cache_maint_engine.sv
module cache_maint_engine
  import cme_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int IDX_W     = 30,
  parameter int SETS_LOG2 = 4,
  parameter int WAYS_LOG2 = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              cache_en,
  output logic              event_en,
  output logic              ecc_en,
  output logic              cmd_valid,
  output logic [1:0]        cmd_op,
  output logic [IDX_W-1:0]  cmd_index,
  input  logic              cmd_ack
);
  logic             eng_busy;
  logic [IDX_W-1:0] lo_idx, hi_idx;
  logic             scope_q;
  maint_op_e        op_q;
  logic             launch, launch_scope;
  maint_op_e        launch_op;
  maint_op_e        walk_op;

  cme_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .eng_busy(eng_busy),
    .cache_en(cache_en), .event_en(event_en), .ecc_en(ecc_en),
    .lo_idx(lo_idx), .hi_idx(hi_idx),
    .scope_q(scope_q), .op_q(op_q),
    .launch(launch), .launch_scope(launch_scope), .launch_op(launch_op)
  );

  cme_walker #(.IDX_W(IDX_W), .SETS_LOG2(SETS_LOG2), .WAYS_LOG2(WAYS_LOG2)) u_walk (
    .clk(clk), .rst(rst),
    .launch(launch), .launch_scope(launch_scope), .launch_op(launch_op),
    .lo_idx(lo_idx), .hi_idx(hi_idx),
    .cmd_ack(cmd_ack),
    .busy(eng_busy),
    .cmd_valid(cmd_valid), .cmd_index(cmd_index), .cmd_op(walk_op)
  );

  assign cmd_op = walk_op;
endmodule

// File: rtl/cme_checker.sv
module cme_checker #(
  parameter int ADDR_W    = 8,
  parameter int IDX_W     = 30,
  parameter int SETS_LOG2 = 4,
  parameter int WAYS_LOG2 = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              cmd_valid,
  input logic              cmd_ack,
  input logic [IDX_W-1:0]  cmd_index,
  input logic [1:0]        cmd_op,
  input logic              eng_busy,
  input logic [IDX_W-1:0]  lo_idx,
  input logic [IDX_W-1:0]  hi_idx,
  input logic              scope_q
);
  localparam logic [IDX_W:0] WHOLE_LINES = (IDX_W+1)'(1) << (SETS_LOG2 + WAYS_LOG2);
  localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(8'h24);

  logic [IDX_W:0] last_q;
  logic           seen_q;

  always_ff @(posedge clk) begin
    if (rst || !eng_busy) begin
      seen_q <= 1'b0;
      last_q <= '0;
    end else if (cmd_valid && cmd_ack) begin
      seen_q <= 1'b1;
      last_q <= {1'b0, cmd_index};
    end
  end

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ack) |=> (cmd_valid && $stable(cmd_index) && $stable(cmd_op)));

  // R5
  valid_needs_busy_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (eng_busy && (cmd_op != 2'd0)));

  // R6
  ascending_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(cmd_valid) && seen_q) |-> ({1'b0, cmd_index} == last_q + 1'b1));

  // R6
  range_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && scope_q) |-> ((cmd_index >= lo_idx) && (cmd_index < hi_idx)));

  // R8
  whole_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !scope_q) |-> ({1'b0, cmd_index} < WHOLE_LINES));

  // R9
  empty_range_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(eng_busy) && scope_q && (lo_idx >= hi_idx)) |=> !eng_busy);

  // R10
  lo_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (eng_busy && wr_en && (wr_addr == A_LO)) |=> $stable(lo_idx));
endmodule

bind cache_maint_engine cme_checker #(
  .ADDR_W(ADDR_W), .IDX_W(IDX_W), .SETS_LOG2(SETS_LOG2), .WAYS_LOG2(WAYS_LOG2)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
  .cmd_valid(cmd_valid), .cmd_ack(cmd_ack), .cmd_index(cmd_index), .cmd_op(cmd_op),
  .eng_busy(eng_busy), .lo_idx(lo_idx), .hi_idx(hi_idx), .scope_q(scope_q)
);

// File: tb/cache_maint_engine_test.sv
`timescale 1ns/1ps
module cache_maint_engine_test;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 30;
  localparam int WHOLE  = 64;  // 2^(4+2) with default geometry

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [DATA_W-1:0] rd_data;
  logic cache_en, event_en, ecc_en, cmd_valid;
  logic [1:0] cmd_op;
  logic [IDX_W-1:0] cmd_index;
  logic cmd_ack = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [IDX_W-1:0] log_idx [0:127];
  logic [1:0]       log_op  [0:127];
  int log_n = 0;
  int dly_seed = 0;
  int dly_cnt = 0;

  always #4 clk = ~clk;

  cache_maint_engine uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .cache_en(cache_en), .event_en(event_en), .ecc_en(ecc_en),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_index(cmd_index), .cmd_ack(cmd_ack)
  );

  // Cache-side responder: acknowledges after a rotating 0..2 cycle delay.
  always @(negedge clk) begin
    if (rst) begin
      cmd_ack = 1'b0;
    end else if (cmd_ack) begin
      cmd_ack = 1'b0;
    end else if (cmd_valid) begin
      if (dly_cnt == 0) begin
        if (log_n < 128) begin
          log_idx[log_n] = cmd_index;
          log_op[log_n]  = cmd_op;
        end
        log_n++;
        cmd_ack  = 1'b1;
        dly_seed = (dly_seed + 1) % 3;
        dly_cnt  = dly_seed;
      end else begin
        dly_cnt--;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] v;
    int n;
    n = 0;
    v = 32'h1;
    while (v[0] && n < 2000) begin
      reg_rd(8'h20, v);
      n++;
    end
    check(req, {31'd0, v[0]}, 32'd0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    reg_rd(8'h00, v); check("R1 gctrl", v, 0);
    reg_rd(8'h04, v); check("R1 aux", v, 0);
    reg_rd(8'h20, v); check("R1 mctrl", v, 0);
    reg_rd(8'h24, v); check("R1 lo", v, 0);
    reg_rd(8'h28, v); check("R1 hi", v, 0);
    check("R1 outputs", {29'd0, cache_en, event_en, ecc_en}, 0);
    check("R1 no command", {31'd0, cmd_valid}, 0);
  endtask

  task automatic t_enables();
    logic [31:0] v;
    reg_wr(8'h00, 32'hFFFF_FFFF);
    reg_rd(8'h00, v); check("R2 gctrl readback", v, 32'h1);
    check("R2 cache_en", {31'd0, cache_en}, 1);
    reg_wr(8'h04, 32'hFFFF_FFFF);
    reg_rd(8'h04, v); check("R3 aux readback", v, 32'h0080_0100);
    check("R3 enables", {30'd0, event_en, ecc_en}, 32'h3);
    reg_wr(8'h04, 32'h0000_0100);
    reg_rd(8'h04, v); check("R3 ecc only", v, 32'h0000_0100);
    check("R3 event off", {31'd0, event_en}, 0);
    reg_wr(8'h00, 32'h0);
    check("R2 cache off", {31'd0, cache_en}, 0);
    reg_rd(8'h3C, v); check("R12 unmapped", v, 0);
  endtask

  task automatic t_index_width();
    logic [31:0] v;
    reg_wr(8'h24, 32'hFFFF_FFFF);
    reg_rd(8'h24, v); check("R4 lo width", v, 32'h3FFF_FFFF);
    reg_wr(8'h28, 32'hC000_0005);
    reg_rd(8'h28, v); check("R4 hi width", v, 32'h5);
  endtask

  task automatic run_range(input logic [29:0] lo, input logic [29:0] hi, input logic [1:0] op,
                           input string req);
    logic [31:0] v;
    int base, cnt;
    reg_wr(8'h24, {2'b0, lo});
    reg_wr(8'h28, {2'b0, hi});
    base = log_n;
    reg_wr(8'h20, {28'd0, 1'b1, op, 1'b1});
    wait_idle({req, " done"});
    cnt = (hi > lo) ? int'(hi - lo) : 0;
    check({req, " count"}, log_n - base, cnt);
    for (int i = 0; i < cnt; i++) begin
      check({req, " index"}, {2'b0, log_idx[base+i]}, {2'b0, lo} + i);
      check({req, " op"}, {30'd0, log_op[base+i]}, {30'd0, op});
    end
    reg_rd(8'h20, v); check("R5 fields after walk", v, {28'd0, 1'b1, op, 1'b0});
  endtask

  task automatic t_range();
    run_range(30'd10, 30'd15, 2'd1, "R6 clean range");
    run_range(30'h3FFF_FFFC, 30'h3FFF_FFFF, 2'd3, "R6 top-of-space range");
  endtask

  task automatic t_whole();
    int base;
    reg_wr(8'h24, 32'd500);
    reg_wr(8'h28, 32'd502);
    base = log_n;
    reg_wr(8'h20, 32'h0000_0007);  // whole scope, flush, start
    wait_idle("R8 whole done");
    check("R8 whole count", log_n - base, WHOLE);
    for (int i = 0; i < WHOLE; i++) begin
      check("R8 whole index", {2'b0, log_idx[base+i]}, i);
      check("R8 whole op", {30'd0, log_op[base+i]}, 32'd3);
    end
  endtask

  task automatic t_empty();
    run_range(30'd20, 30'd20, 2'd1, "R9 equal bounds");
    run_range(30'd30, 30'd5, 2'd2, "R9 inverted bounds");
  endtask

  task automatic t_busy_ignore();
    logic [31:0] v;
    int base;
    reg_wr(8'h24, 32'd0);
    reg_wr(8'h28, 32'd8);
    base = log_n;
    reg_wr(8'h20, 32'h0000_000D);  // range, invalidate, start
    reg_wr(8'h24, 32'd100);
    reg_wr(8'h28, 32'd200);
    reg_wr(8'h20, 32'h0000_0007);
    reg_rd(8'h20, v); check("R5 status busy", v, 32'hD);
    wait_idle("R10 done");
    check("R10 count", log_n - base, 8);
    for (int i = 0; i < 8; i++)
      check("R10 op kept", {30'd0, log_op[base+i]}, 32'd2);
    reg_rd(8'h24, v); check("R10 lo kept", v, 0);
    reg_rd(8'h28, v); check("R10 hi kept", v, 8);
    reg_rd(8'h20, v); check("R10 mctrl kept", v, 32'hC);
  endtask

  task automatic t_op_zero();
    logic [31:0] v;
    int base;
    reg_wr(8'h24, 32'd0);
    reg_wr(8'h28, 32'd4);
    base = log_n;
    reg_wr(8'h20, 32'h0000_0009);  // range, op 0, start
    reg_rd(8'h20, v); check("R11 no launch", v, 32'h8);
    repeat (10) @(negedge clk);
    check("R11 no commands", log_n - base, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_enables();
    t_index_width();
    t_range();
    t_whole();
    t_empty();
    t_busy_ignore();
    t_op_zero();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule